// File: doc/BRIEF.md
# Mixed Page Size Translation Buffer

This block caches virtual-to-physical page translations for one processor. A single lookup covers both classes of page: normal pages (4 KB, 8 KB, 16 KB) and large pages (4 MB, 8 MB, 16 MB). Both classes share one set-associative array (256 sets of 4 ways by default). Each lookup makes two probes into the array in the same cycle. One probe indexes with the bits above the largest normal page. The other indexes with the bits above the largest large page. Each entry holds its own size code, and that code decides which address bits take part in the tag compare and which bits pass straight through to the physical address.

Every entry carries an address-space identifier and a shared flag. A shared entry answers to any identifier, so one mapping serves many processes without a flush. The refill port writes one entry and picks the way itself. The invalidate port either clears everything or clears the private entries of one identifier. It does this as a sweep of one set per clock, during which the block reports itself busy.

The controller has two states. In READY it serves lookups and refills. In SWEEP it clears one set per cycle. The transition START_SWEEP (READY to SWEEP) is taken on an invalidate request. The transition SWEEP_DONE (SWEEP to READY) is taken after the last set has been cleared.

Top module: `tlb_mps`

## Requirements
- R1: After reset every entry is invalid, `busy` and `rsp_vld` are low, and any lookup misses.
- R2: A lookup requested while `busy` is low is answered on the next clock with `rsp_vld` high and exactly one of `rsp_hit` or `rsp_miss` high.
- R3: Normal size codes 0, 1 and 2 stand for 4 KB, 8 KB and 16 KB pages. Such an entry matches when virtual address bits 31 down to (12 + code) are equal. On a hit, physical address bits below (12 + code) come from the virtual address and the bits above come from the stored frame number.
- R4: Large size codes 4, 5 and 6 stand for 4 MB, 8 MB and 16 MB pages. The same rule applies with offset width (22 + code[1:0]).
- R5: An entry matches only if its identifier equals `lk_asid` or its shared flag is set. All 64 identifier values are usable.
- R6: Normal entries are placed in and probed at the set given by virtual address bits [14 +: index width]. Large entries use bits [24 +: index width]. Both probes happen in one lookup, and a normal-page hit takes precedence.
- R7: A refill goes to the lowest-numbered invalid way of its set. If no way is invalid, it goes to the way named by that set's round-robin pointer, which starts at way 0 and then advances by one.
- R8: `inv_all` clears every entry, shared ones included.
- R9: `inv_asid_en` clears only the entries that are valid, not shared, and carry `inv_asid`. All other entries keep translating.
- R10: An accepted invalidate raises `busy` on the next clock for exactly as many cycles as there are sets. While busy, lookups get no response and refills are dropped.
- R11: A hit returns the stored permission bits. A miss returns zero on `rsp_pa` and `rsp_perm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Identifier of the running process |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation not found |
| rsp_pa | output | PA_W | Physical address (40 bits by default) |
| rsp_perm | output | PERM_W | Permission bits of the matching entry |
| wr_en | input | 1 | Refill strobe |
| wr_va | input | VA_W | Virtual address of the refilled page |
| wr_asid | input | ASID_W | Identifier stored with the entry |
| wr_shared | input | 1 | Entry matches any identifier |
| wr_size | input | 3 | Page size code (0,1,2 normal; 4,5,6 large) |
| wr_pfn | input | PA_W-12 | Physical frame number (address bits 39:12) |
| wr_perm | input | PERM_W | Permission bits to store |
| inv_all | input | 1 | Request to clear every entry |
| inv_asid_en | input | 1 | Request to clear the private entries of one identifier |
| inv_asid | input | ASID_W | Identifier to clear |
| busy | output | 1 | Sweep in progress |

## Verification
The bench goes through all six size codes at several offsets inside each page and at the first address past the page. A wrong offset mask would either leak frame bits into the offset or turn the neighbouring page into a hit. It fills a set past its capacity, punches a hole with an identifier invalidate, and refills twice. This exposes a victim choice that ignores invalid ways or a pointer that moves when it should not, because the wrong surviving entry would then hit. It also checks that shared entries survive an identifier invalidate but not a full one, that a normal mapping wins over a large one covering the same address, and that a refill or lookup issued during the sweep leaves no trace.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PG_SHIFT    = 12;
    localparam int LARGE_EXTRA = 10;
    localparam int NRM_IDX_LO  = 2;
    localparam int LRG_IDX_LO  = 12;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_SWEEP = 1'b1
    } tlb_state_t;

    function automatic logic [4:0] span_of(input logic [2:0] sz);
        return sz[2] ? (5'(LARGE_EXTRA) + {3'b0, sz[1:0]}) : {3'b0, sz[1:0]};
    endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 28,
    parameter int ASID_W = 6
) (
    input  logic              e_vld,
    input  logic              e_shr,
    input  logic [ASID_W-1:0] e_asid,
    input  logic [2:0]        e_size,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [PFN_W-1:0]  e_pfn,
    input  logic              want_large,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic              hit,
    output logic [PFN_W-1:0]  pa_pn
);
    logic [4:0]       span;
    logic [VPN_W-1:0] keep_v;
    logic [PFN_W-1:0] keep_p;

    always_comb begin
        span   = span_of(e_size);
        keep_v = ~((VPN_W'(1) << span) - VPN_W'(1));
        keep_p = ~((PFN_W'(1) << span) - PFN_W'(1));
        hit    = e_vld && (e_size[2] == want_large)
                 && (((e_vpn ^ q_vpn) & keep_v) == '0)
                 && (e_shr || (e_asid == q_asid));
        pa_pn  = (e_pfn & keep_p) | (PFN_W'(q_vpn) & ~keep_p);
    end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  way_vld,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             advance
);
    always_comb begin
        victim  = rr_ptr;
        advance = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_vld[w]) begin
                victim  = WAY_W'(w);
                advance = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlb_mps.sv
module tlb_mps
    import tlb_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 40,
    parameter int ASID_W = 6,
    parameter int PERM_W = 3,
    parameter int SETS   = 256,
    parameter int WAYS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_req,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [ASID_W-1:0]    lk_asid,
    output logic                 rsp_vld,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [PA_W-1:0]      rsp_pa,
    output logic [PERM_W-1:0]    rsp_perm,
    input  logic                 wr_en,
    input  logic [VA_W-1:0]      wr_va,
    input  logic [ASID_W-1:0]    wr_asid,
    input  logic                 wr_shared,
    input  logic [2:0]           wr_size,
    input  logic [PA_W-13:0]     wr_pfn,
    input  logic [PERM_W-1:0]    wr_perm,
    input  logic                 inv_all,
    input  logic                 inv_asid_en,
    input  logic [ASID_W-1:0]    inv_asid,
    output logic                 busy
);
    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PFN_W = PA_W - PG_SHIFT;
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic              ent_v    [SETS][WAYS];
    logic              ent_shr  [SETS][WAYS];
    logic [ASID_W-1:0] ent_asid [SETS][WAYS];
    logic [2:0]        ent_size [SETS][WAYS];
    logic [VPN_W-1:0]  ent_vpn  [SETS][WAYS];
    logic [PFN_W-1:0]  ent_pfn  [SETS][WAYS];
    logic [PERM_W-1:0] ent_perm [SETS][WAYS];
    logic [WAY_W-1:0]  rr_ptr   [SETS];

    tlb_state_t        state, state_nx;
    logic [IDX_W-1:0]  sweep_idx;
    logic              sweep_all;
    logic [ASID_W-1:0] sweep_asid;
    logic              inv_req, ready, sweep_last;

    assign ready      = (state == ST_READY);
    assign busy       = (state == ST_SWEEP);
    assign inv_req    = inv_all || inv_asid_en;
    assign sweep_last = (sweep_idx == IDX_W'(SETS - 1));

    // ---------------- lookup: two probes in one cycle ----------------
    logic [VPN_W-1:0] lk_vpn;
    logic [IDX_W-1:0] idx_n, idx_l;
    logic [WAYS-1:0]  hit_n, hit_l;
    logic [PFN_W-1:0] pn_n [WAYS];
    logic [PFN_W-1:0] pn_l [WAYS];

    assign lk_vpn = lk_va[VA_W-1:PG_SHIFT];
    assign idx_n  = lk_vpn[NRM_IDX_LO +: IDX_W];
    assign idx_l  = lk_vpn[LRG_IDX_LO +: IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_probe
        tlb_entry_match #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_nrm (
            .e_vld(ent_v[idx_n][w]), .e_shr(ent_shr[idx_n][w]),
            .e_asid(ent_asid[idx_n][w]), .e_size(ent_size[idx_n][w]),
            .e_vpn(ent_vpn[idx_n][w]), .e_pfn(ent_pfn[idx_n][w]),
            .want_large(1'b0), .q_vpn(lk_vpn), .q_asid(lk_asid),
            .hit(hit_n[w]), .pa_pn(pn_n[w]));
        tlb_entry_match #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_lrg (
            .e_vld(ent_v[idx_l][w]), .e_shr(ent_shr[idx_l][w]),
            .e_asid(ent_asid[idx_l][w]), .e_size(ent_size[idx_l][w]),
            .e_vpn(ent_vpn[idx_l][w]), .e_pfn(ent_pfn[idx_l][w]),
            .want_large(1'b1), .q_vpn(lk_vpn), .q_asid(lk_asid),
            .hit(hit_l[w]), .pa_pn(pn_l[w]));
    end

    logic              any_hit;
    logic [PFN_W-1:0]  sel_pn;
    logic [PERM_W-1:0] sel_perm;

    always_comb begin
        any_hit  = 1'b0;
        sel_pn   = '0;
        sel_perm = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_l[w]) begin
                any_hit  = 1'b1;
                sel_pn   = pn_l[w];
                sel_perm = ent_perm[idx_l][w];
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_n[w]) begin
                any_hit  = 1'b1;
                sel_pn   = pn_n[w];
                sel_perm = ent_perm[idx_n][w];
            end
        end
    end

    // ---------------- refill way choice ----------------
    logic [VPN_W-1:0] wr_vpn;
    logic [IDX_W-1:0] widx;
    logic [WAYS-1:0]  set_vld;
    logic [WAY_W-1:0] victim;
    logic             advance;

    assign wr_vpn = wr_va[VA_W-1:PG_SHIFT];
    assign widx   = wr_size[2] ? wr_vpn[LRG_IDX_LO +: IDX_W] : wr_vpn[NRM_IDX_LO +: IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_vld
        assign set_vld[w] = ent_v[widx][w];
    end

    tlb_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .way_vld(set_vld), .rr_ptr(rr_ptr[widx]), .victim(victim), .advance(advance));

    // ---------------- state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: if (inv_req)    state_nx = ST_SWEEP;
            ST_SWEEP: if (sweep_last) state_nx = ST_READY;
        endcase
    end

    // ---------------- storage, sweep and outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_ptr[s] <= '0;
                for (int w = 0; w < WAYS; w++) ent_v[s][w] <= 1'b0;
            end
            sweep_idx  <= '0;
            sweep_all  <= 1'b0;
            sweep_asid <= '0;
            rsp_vld    <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_pa     <= '0;
            rsp_perm   <= '0;
        end else begin
            rsp_vld  <= lk_req && ready;
            rsp_hit  <= lk_req && ready && any_hit;
            rsp_miss <= lk_req && ready && !any_hit;
            rsp_pa   <= (lk_req && ready && any_hit) ? {sel_pn, lk_va[PG_SHIFT-1:0]} : '0;
            rsp_perm <= (lk_req && ready && any_hit) ? sel_perm : '0;
            unique case (state)
                ST_READY: begin
                    sweep_idx <= '0;
                    if (inv_req) begin
                        sweep_all  <= inv_all;
                        sweep_asid <= inv_asid;
                    end else if (wr_en) begin
                        ent_v[widx][victim]    <= 1'b1;
                        ent_shr[widx][victim]  <= wr_shared;
                        ent_asid[widx][victim] <= wr_asid;
                        ent_size[widx][victim] <= wr_size;
                        ent_vpn[widx][victim]  <= wr_vpn;
                        ent_pfn[widx][victim]  <= wr_pfn;
                        ent_perm[widx][victim] <= wr_perm;
                        if (advance) rr_ptr[widx] <= rr_ptr[widx] + 1'b1;
                    end
                end
                ST_SWEEP: begin
                    sweep_idx <= sweep_idx + 1'b1;
                    for (int w = 0; w < WAYS; w++) begin
                        if (sweep_all || (!ent_shr[sweep_idx][w] && ent_asid[sweep_idx][w] == sweep_asid))
                            ent_v[sweep_idx][w] <= 1'b0;
                    end
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R2
    rsp_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_hit != rsp_miss));
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !busy) |=> rsp_vld);
    // R10
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_vld);
    // R10
    inv_enters_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (inv_all || inv_asid_en)) |=> busy);
    // R11
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_pa == '0 && rsp_perm == '0));
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[PG_SHIFT-1:0] == $past(lk_va[PG_SHIFT-1:0])));
    // R3
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_size[1:0] != 2'b11));
endmodule

// File: tb/tlb_mps_tb.sv
module tlb_mps_tb_top;
    localparam int SETS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [5:0]  lk_asid = '0;
    logic        rsp_vld, rsp_hit, rsp_miss, busy;
    logic [39:0] rsp_pa;
    logic [2:0]  rsp_perm;
    logic        wr_en = 1'b0;
    logic [31:0] wr_va = '0;
    logic [5:0]  wr_asid = '0;
    logic        wr_shared = 1'b0;
    logic [2:0]  wr_size = '0;
    logic [27:0] wr_pfn = '0;
    logic [2:0]  wr_perm = '0;
    logic        inv_all = 1'b0;
    logic        inv_asid_en = 1'b0;
    logic [5:0]  inv_asid = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tlb_mps #(.SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
        .rsp_perm(rsp_perm), .wr_en(wr_en), .wr_va(wr_va), .wr_asid(wr_asid),
        .wr_shared(wr_shared), .wr_size(wr_size), .wr_pfn(wr_pfn), .wr_perm(wr_perm),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid), .busy(busy));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] calc_pa(input logic [31:0] va, input logic [27:0] pfn, input logic [2:0] sz);
        int off = (sz[2] ? 22 : 12) + int'(sz[1:0]);
        logic [39:0] m = (40'd1 << off) - 40'd1;
        return ({pfn, 12'h000} & ~m) | ({8'h00, va} & m);
    endfunction

    task automatic refill(input logic [31:0] va, input logic [5:0] asid, input bit shr,
                          input logic [2:0] sz, input logic [27:0] pfn, input logic [2:0] perm);
        @(negedge clk);
        wr_en = 1'b1; wr_va = va; wr_asid = asid; wr_shared = shr;
        wr_size = sz; wr_pfn = pfn; wr_perm = perm;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [31:0] va, input logic [5:0] asid);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_asid = asid;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] va, input logic [5:0] asid,
                              input logic [39:0] pa, input logic [2:0] perm, input string req);
        probe(va, asid);
        check(rsp_vld && rsp_hit && !rsp_miss, req, {61'b0, rsp_vld, rsp_hit, rsp_miss}, 64'b110);
        check(rsp_pa == pa, req, 64'(rsp_pa), 64'(pa));
        check(rsp_perm == perm, req, 64'(rsp_perm), 64'(perm));
    endtask

    task automatic expect_miss(input logic [31:0] va, input logic [5:0] asid, input string req);
        probe(va, asid);
        check(rsp_vld && !rsp_hit && rsp_miss, req, {61'b0, rsp_vld, rsp_hit, rsp_miss}, 64'b101);
        // R11: miss returns zero address and permissions
        check(rsp_pa == '0 && rsp_perm == '0, "R11", {21'b0, rsp_perm, rsp_pa}, 64'd0);
    endtask

    task automatic invalidate(input bit all, input logic [5:0] asid, input string req);
        int cnt = 0;
        @(negedge clk);
        inv_all = all; inv_asid_en = !all; inv_asid = asid;
        @(negedge clk);
        inv_all = 1'b0; inv_asid_en = 1'b0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        // R10: busy spans one cycle per set
        check(cnt == SETS, req, 64'(cnt), 64'(SETS));
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [31:0] base, va;
        logic [27:0] pfn;
        logic [31:0] rv [7];
        int off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(!busy && !rsp_vld, "R1", {62'b0, busy, rsp_vld}, 64'd0);
        expect_miss(32'h1234_5678, 6'd0, "R1");
        expect_miss(32'hFFC0_0ABC, 6'd63, "R1");

        // R3 / R4: every size code, offsets inside the page and the next page
        for (int code = 0; code < 7; code++) begin
            if (code == 3) continue;
            off  = (code >= 4 ? 22 : 12) + (code % 4);
            base = 32'h6B40_0000 & ~((32'd1 << off) - 32'd1);
            pfn  = 28'hABC_DE57 + 28'(code * 28'h111);
            invalidate(1'b1, 6'd0, "R10");
            refill(base, 6'd3, 1'b0, 3'(code), pfn, 3'(code));
            for (int k = 0; k < 4; k++) begin
                va = base + (32'(k) << (off - 2)) + 32'h123;
                expect_hit(va, 6'd3, calc_pa(va, pfn, 3'(code)), 3'(code), code >= 4 ? "R4" : "R3");
            end
            expect_miss(base + (32'd1 << off), 6'd3, code >= 4 ? "R4" : "R3");
        end

        // R5: identifier match and shared entries
        invalidate(1'b1, 6'd0, "R8");
        refill(32'h0000_8000, 6'd5, 1'b0, 3'd0, 28'h000_0111, 3'd1);
        refill(32'h0001_C000, 6'd5, 1'b1, 3'd0, 28'h000_0222, 3'd2);
        expect_hit(32'h0000_8010, 6'd5, 40'h00_0011_1010, 3'd1, "R5");
        expect_miss(32'h0000_8010, 6'd6, "R5");
        expect_hit(32'h0001_C020, 6'd6, 40'h00_0022_2020, 3'd2, "R5");
        expect_hit(32'h0001_C020, 6'd63, 40'h00_0022_2020, 3'd2, "R5");

        // R6: normal page wins over a large page covering it
        invalidate(1'b1, 6'd0, "R8");
        refill(32'h1234_5000, 6'd1, 1'b0, 3'd0, 28'h0AA_AAAA, 3'd3);
        refill(32'h1234_5000, 6'd1, 1'b0, 3'd4, 28'h055_5400, 3'd4);
        expect_hit(32'h1234_5ABC, 6'd1, 40'h0A_AAAA_AABC, 3'd3, "R6");
        va = 32'h1234_6ABC;
        expect_hit(va, 6'd1, calc_pa(va, 28'h055_5400, 3'd4), 3'd4, "R6");

        // R7 / R9: replacement order, identifier invalidate, invalid-first refill
        invalidate(1'b1, 6'd0, "R8");
        for (int i = 0; i < 7; i++) rv[i] = 32'h0010_0000 * (i + 1);
        refill(32'h0000_4000, 6'd2, 1'b1, 3'd0, 28'h000_0777, 3'd7);
        for (int i = 0; i < 4; i++) refill(rv[i], i == 2 ? 6'd2 : 6'd1, 1'b0, 3'd0, 28'(i + 1), 3'd1);
        for (int i = 0; i < 4; i++) expect_hit(rv[i], 6'd1 + 6'(i == 2), {28'(i + 1), 12'h0}, 3'd1, "R7");
        refill(rv[4], 6'd1, 1'b0, 3'd0, 28'd5, 3'd1);
        expect_miss(rv[0], 6'd1, "R7");
        for (int i = 1; i < 5; i++) expect_hit(rv[i], 6'd1 + 6'(i == 2), {28'(i + 1), 12'h0}, 3'd1, "R7");
        invalidate(1'b0, 6'd2, "R9");
        expect_miss(rv[2], 6'd2, "R9");
        expect_hit(rv[1], 6'd1, {28'd2, 12'h0}, 3'd1, "R9");
        expect_hit(rv[3], 6'd1, {28'd4, 12'h0}, 3'd1, "R9");
        expect_hit(32'h0000_4000, 6'd2, {28'h000_0777, 12'h0}, 3'd7, "R9");
        refill(rv[5], 6'd1, 1'b0, 3'd0, 28'd6, 3'd1);
        for (int i = 1; i < 6; i++)
            if (i != 2) expect_hit(rv[i], 6'd1, {28'(i + 1), 12'h0}, 3'd1, "R7");
        refill(rv[6], 6'd1, 1'b0, 3'd0, 28'd7, 3'd1);
        expect_miss(rv[1], 6'd1, "R7");
        for (int i = 3; i < 7; i++) expect_hit(rv[i], 6'd1, {28'(i + 1), 12'h0}, 3'd1, "R7");

        // R8: full invalidate drops shared entries too
        invalidate(1'b1, 6'd0, "R8");
        expect_miss(32'h0000_4000, 6'd2, "R8");
        expect_miss(rv[3], 6'd1, "R8");

        // R10: lookup and refill issued during the sweep are ignored
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        lk_req = 1'b1; lk_va = 32'h0000_9000; lk_asid = 6'd0;
        wr_en = 1'b1; wr_va = 32'h0000_9000; wr_asid = 6'd0; wr_shared = 1'b1;
        wr_size = 3'd0; wr_pfn = 28'h123_4567; wr_perm = 3'd5;
        @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b0;
        check(!rsp_vld && busy, "R10", {62'b0, rsp_vld, busy}, 64'b01);
        while (busy) @(negedge clk);
        expect_miss(32'h0000_9000, 6'd0, "R10");

        report();
    end
endmodule